// File: doc/BRIEF.md
# Serial GPIO Shift-Chain Master

This block turns a few wires into up to eighty general-purpose pins. It drives an external daisy chain of 8-bit parallel-load input registers and 8-bit latched output registers. It runs frames one after another. Each frame starts with one shift-clock period in which a strobe loads the external input registers and updates the external output registers. Then, for each active pin, one shift-clock period moves one output bit out and one input bit in. The highest-numbered pin goes first in both directions.

A control word turns the chain on, sets the pin count in groups of eight, and sets a 16-bit divider. One shift-clock period lasts 2 × (divider + 1) system clocks. The block takes a copy of the divider, the pin count and the output latch when a frame starts. When a frame ends, the sampled inputs move into a value register in one step, and a one-cycle frame-done pulse goes to the interrupt logic. Both the value register and the output latch are organised as 32-bit banks, and software reads them back on separate paths: the value path returns sampled inputs, the latch path returns what was written.

Top module: `shift_chain_gpio`

## Requirements
- R1: After reset the serial clock, load strobe, serial data out and frame-done are 0, and the control word, every bank of the value register and every bank of the output latch read 0.
- R2: The control word keeps only bit 0 (enable), bits 9:6 (pin groups, pins = groups × 8) and bits 31:16 (divider). A write takes effect on the next clock. All other bits read back as 0.
- R3: No frame starts while enable is 0, the group field is 0, or the group field is above 10. In that case the serial clock, strobe and data out stay 0.
- R4: A frame is one strobe period followed by N shift periods, each 2 × (divider + 1) clocks long. During the strobe period the load strobe is 1 and the serial clock is 0. Each shift period has a low half followed by a high half, each (divider + 1) clocks long. The strobe and the serial clock are never 1 together.
- R5: During shift period k (k = 0 first), serial data out carries output-latch bit N−1−k, as copied at frame start. It changes only as a period begins, stays steady through the high half, and is 0 outside shift periods.
- R6: Serial data in is sampled in the last clock of each low half. The bit sampled in period k lands in value bit N−1−k. Value bits at N and above read 0.
- R7: In the first clock after the last shift period, the value register holds the new frame's samples and frame-done is 1 for exactly that one clock. The value register changes at no other time. If the block is still enabled with a valid group field, the next strobe period begins in that same clock.
- R8: Clearing enable lets the current frame finish. After that the serial clock, strobe and data out stay 0.
- R9: Divider, pin count and output-latch contents are copied when a frame starts. Changing them during a frame affects only later frames.
- R10: The output latch is written as a 32-bit word into bank 0, 1 or 2 (pins 32·b to 32·b+31). Bits for pins above 79 and writes to bank 3 are ignored. The latch path reads these contents back, with 0 for bank 3 and for bits above pin 79.
- R11: The value path of bank b returns pins 32·b to 32·b+31 of the sampled inputs, with 0 for bank 3, independent of what the output latch holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word read-back |
| lat_we | input | 1 | Output latch write strobe |
| lat_bank | input | 2 | Bank selected for an output latch write |
| lat_wdata | input | 32 | Output latch write data |
| rd_bank | input | 2 | Bank selected for both read paths |
| rd_value | output | 32 | Sampled input value of the selected bank |
| rd_latch | output | 32 | Output latch content of the selected bank |
| sclk_o | output | 1 | Shift clock to the chain |
| sload_o | output | 1 | Load/latch strobe to the chain |
| sdout_o | output | 1 | Serial data toward the output registers |
| sdin_i | input | 1 | Serial data from the input registers |
| frame_done_o | output | 1 | One-clock pulse at the end of each frame |

## Verification
A wrong phase or half-period counter moves the serial clock or strobe edge within a few system clocks, so a clock-by-clock comparison of those pins catches it at once. A wrong pin index or a stale snapshot shows up as a wrong serial data bit during the affected shift period. It can also show up at the frame boundary as a wrong value word, or as a frame-done pulse at the wrong time. That boundary lies at most (N+1) shift periods away. The bench models the external chain behaviourally, so a bit-order reversal or a sample taken on the wrong half appears as a value mismatch at the first frame end.

// File: rtl/scg_pkg.sv
package scg_pkg;

  localparam int CTRL_W   = 32;
  localparam int DIV_W    = 16;
  localparam int GRP_W    = 4;
  localparam int PINS_PER_GRP = 8;

  // bits kept by the control word: [31:16] divider, [9:6] groups, [0] enable
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 32'hFFFF_03C1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } scg_state_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [GRP_W-1:0] grp;
    logic             en;
  } scg_cfg_t;

  function automatic scg_cfg_t ctrl_decode(logic [CTRL_W-1:0] w);
    scg_cfg_t c;
    c.div = w[31:16];
    c.grp = w[9:6];
    c.en  = w[0];
    return c;
  endfunction

  function automatic logic grp_valid(logic [GRP_W-1:0] g, int max_grp);
    return (g != '0) && (int'(g) <= max_grp);
  endfunction

  function automatic int pin_count(logic [GRP_W-1:0] g);
    return int'(g) * PINS_PER_GRP;
  endfunction

endpackage

// File: rtl/scg_regs.sv
module scg_regs
  import scg_pkg::*;
#(
  parameter int MAX_PINS   = 80,
  parameter int BANK_W     = 32,
  parameter int BANK_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_we,
  input  logic [CTRL_W-1:0]     ctrl_wdata,
  output logic [CTRL_W-1:0]     ctrl_q,
  input  logic                  lat_we,
  input  logic [BANK_SEL_W-1:0] lat_bank,
  input  logic [BANK_W-1:0]     lat_wdata,
  input  logic [BANK_SEL_W-1:0] rd_bank,
  input  logic [MAX_PINS-1:0]   value_vec,
  output logic [MAX_PINS-1:0]   latch_vec,
  output logic [BANK_W-1:0]     rd_value,
  output logic [BANK_W-1:0]     rd_latch
);

  localparam int NBANKS = (MAX_PINS + BANK_W - 1) / BANK_W;

  logic [BANK_W-1:0] lat_q   [NBANKS];
  logic [BANK_W-1:0] wmask   [NBANKS];
  logic [BANK_W-1:0] val_bnk [NBANKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata & CTRL_KEEP;
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    for (genvar j = 0; j < BANK_W; j++) begin : g_bit
      if (b * BANK_W + j < MAX_PINS) begin : g_live
        assign wmask[b][j]   = 1'b1;
        assign val_bnk[b][j] = value_vec[b*BANK_W+j];
        assign latch_vec[b*BANK_W+j] = lat_q[b][j];
      end else begin : g_pad
        assign wmask[b][j]   = 1'b0;
        assign val_bnk[b][j] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lat_q[b] <= '0;
      else if (lat_we && int'(lat_bank) == b)
        lat_q[b] <= lat_wdata & wmask[b];
    end
  end

  always_comb begin
    rd_value = '0;
    rd_latch = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (int'(rd_bank) == b) begin
        rd_value = val_bnk[b];
        rd_latch = lat_q[b];
      end
    end
  end

endmodule

// File: rtl/scg_halftimer.sv
module scg_halftimer
  import scg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= DIV_W'(cnt + 1'b1);
  end

endmodule

// File: rtl/scg_engine.sv
module scg_engine
  import scg_pkg::*;
#(
  parameter int MAX_GROUPS = 10,
  parameter int MAX_PINS   = MAX_GROUPS * PINS_PER_GRP,
  parameter int PIN_IDX_W  = $clog2(MAX_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  scg_cfg_t            cfg,
  input  logic [MAX_PINS-1:0] latch_vec,
  input  logic                sdin,
  input  logic                tick,
  output logic                run,
  output logic [DIV_W-1:0]    div_s,
  output logic                sclk,
  output logic                sload,
  output logic                sdout,
  output logic                frame_done,
  output logic [MAX_PINS-1:0] value_vec,
  output logic                cfg_ok,
  output logic                frame_end,
  output logic                is_idle
);

  scg_state_e          state;
  logic                half;
  logic [PIN_IDX_W-1:0] idx;
  logic [MAX_PINS-1:0] snap;
  logic [MAX_PINS-1:0] cap;
  logic                sample_now;
  logic                begin_frame;

  assign cfg_ok      = cfg.en && grp_valid(cfg.grp, MAX_GROUPS);
  assign is_idle     = (state == ST_IDLE);
  assign run         = !is_idle;
  assign sample_now  = (state == ST_SHIFT) && tick && !half;
  assign frame_end   = (state == ST_SHIFT) && tick && half && (idx == '0);
  assign begin_frame = cfg_ok && (is_idle || frame_end);

  assign sclk  = (state == ST_SHIFT) && half;
  assign sload = (state == ST_LOAD);
  assign sdout = (state == ST_SHIFT) ? snap[idx] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      half       <= 1'b0;
      idx        <= '0;
      div_s      <= '0;
      snap       <= '0;
      cap        <= '0;
      value_vec  <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= frame_end;
      if (frame_end) value_vec <= cap;
      if (begin_frame) begin
        state <= ST_LOAD;
        half  <= 1'b0;
        idx   <= PIN_IDX_W'(pin_count(cfg.grp) - 1);
        div_s <= cfg.div;
        snap  <= latch_vec;
        cap   <= '0;
      end else if (frame_end) begin
        state <= ST_IDLE;
        half  <= 1'b0;
      end else if (tick) begin
        half <= !half;
        if (state == ST_LOAD && half) state <= ST_SHIFT;
        if (sample_now) cap[idx] <= sdin;
        if (state == ST_SHIFT && half) idx <= idx - 1'b1;
      end
    end
  end

endmodule

// File: rtl/shift_chain_gpio.sv
module shift_chain_gpio
  import scg_pkg::*;
#(
  parameter int MAX_GROUPS = 10,
  parameter int BANK_W     = 32,
  parameter int BANK_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_we,
  input  logic [31:0]           ctrl_wdata,
  output logic [31:0]           ctrl_rdata,
  input  logic                  lat_we,
  input  logic [BANK_SEL_W-1:0] lat_bank,
  input  logic [BANK_W-1:0]     lat_wdata,
  input  logic [BANK_SEL_W-1:0] rd_bank,
  output logic [BANK_W-1:0]     rd_value,
  output logic [BANK_W-1:0]     rd_latch,
  output logic                  sclk_o,
  output logic                  sload_o,
  output logic                  sdout_o,
  input  logic                  sdin_i,
  output logic                  frame_done_o
);

  localparam int MAX_PINS = MAX_GROUPS * PINS_PER_GRP;

  logic [CTRL_W-1:0]   ctrl_q;
  scg_cfg_t            cfg;
  logic [MAX_PINS-1:0] latch_vec;
  logic [MAX_PINS-1:0] value_vec;
  logic [DIV_W-1:0]    div_s;
  logic                run_w;
  logic                tick_w;
  logic                cfg_ok_w;
  logic                frame_end_w;
  logic                eng_idle_w;

  assign cfg        = ctrl_decode(ctrl_q);
  assign ctrl_rdata = ctrl_q;

  scg_regs #(
    .MAX_PINS(MAX_PINS), .BANK_W(BANK_W), .BANK_SEL_W(BANK_SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .lat_we(lat_we), .lat_bank(lat_bank), .lat_wdata(lat_wdata),
    .rd_bank(rd_bank), .value_vec(value_vec), .latch_vec(latch_vec),
    .rd_value(rd_value), .rd_latch(rd_latch)
  );

  scg_halftimer u_timer (
    .clk(clk), .rst_n(rst_n), .run(run_w), .div(div_s), .tick(tick_w)
  );

  scg_engine #(
    .MAX_GROUPS(MAX_GROUPS), .MAX_PINS(MAX_PINS)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .latch_vec(latch_vec),
    .sdin(sdin_i), .tick(tick_w), .run(run_w), .div_s(div_s),
    .sclk(sclk_o), .sload(sload_o), .sdout(sdout_o),
    .frame_done(frame_done_o), .value_vec(value_vec),
    .cfg_ok(cfg_ok_w), .frame_end(frame_end_w), .is_idle(eng_idle_w)
  );

endmodule

// File: rtl/scg_chk.sv
module scg_chk #(
  parameter int MAX_PINS = 80
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sclk_o,
  input logic                sload_o,
  input logic                sdout_o,
  input logic                frame_done_o,
  input logic                frame_end_w,
  input logic                cfg_ok_w,
  input logic                eng_idle_w,
  input logic [MAX_PINS-1:0] value_vec
);

  // R4
  strobe_clock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sload_o && sclk_o));

  // R5
  sdout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sdout_o));

  // R7
  done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_w |=> frame_done_o);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  // R7
  value_moves_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(value_vec) |-> frame_done_o);

  // R3
  invalid_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle_w && !cfg_ok_w) |=> (!sclk_o && !sload_o));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle_w |-> (!sclk_o && !sload_o && !sdout_o));

endmodule

bind shift_chain_gpio scg_chk #(.MAX_PINS(MAX_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .sload_o(sload_o),
  .sdout_o(sdout_o), .frame_done_o(frame_done_o), .frame_end_w(frame_end_w),
  .cfg_ok_w(cfg_ok_w), .eng_idle_w(eng_idle_w), .value_vec(value_vec)
);

// File: tb/shift_chain_gpio_tb.sv
module shift_chain_gpio_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic        lat_we = 1'b0;
  logic [1:0]  lat_bank = '0;
  logic [31:0] lat_wdata = '0;
  logic [1:0]  rd_bank = '0;
  logic [31:0] rd_value, rd_latch;
  logic        sclk_o, sload_o, sdout_o, frame_done_o;
  logic        sdin_i;

  always #10 clk = ~clk;

  shift_chain_gpio u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .lat_we(lat_we), .lat_bank(lat_bank),
    .lat_wdata(lat_wdata), .rd_bank(rd_bank), .rd_value(rd_value),
    .rd_latch(rd_latch), .sclk_o(sclk_o), .sload_o(sload_o),
    .sdout_o(sdout_o), .sdin_i(sdin_i), .frame_done_o(frame_done_o)
  );

  int compared = 0, mismatched = 0, frames = 0;
  bit finished = 0, mon_on = 0;

  // reference model state
  logic [31:0] ctrl_m = '0;
  logic [79:0] latch_m = '0, snap_m = '0, exp_val = '0;
  logic [79:0] in_pins = '0, chain_vec = '0;
  int chain_idx = -1;
  bit active = 0, prev_sclk = 0;
  int t = 0, per_m = 2, n_m = 8;
  bit pc = 0, pl = 0;
  logic [31:0] pc_val, pl_val;
  int pl_b;

  assign sdin_i = (chain_idx >= 0 && chain_idx < 80) ? chain_vec[chain_idx] : 1'b0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] slice(logic [79:0] v, int b);
    logic [31:0] r = '0;
    for (int j = 0; j < 32; j++)
      if (b < 3 && b * 32 + j < 80) r[j] = v[b*32+j];
    return r;
  endfunction

  function automatic bit ctrl_valid(logic [31:0] c);
    return c[0] && c[9:6] != 0 && c[9:6] <= 10;
  endfunction

  function automatic void start_frame();
    active = 1; t = 0;
    per_m = 2 * (int'(ctrl_m[31:16]) + 1);
    n_m = int'(ctrl_m[9:6]) * 8;
    snap_m = latch_m;
  endfunction

  task automatic mon_step();
    bit e_done = 0, e_clk = 0, e_ld = 0, e_do = 0;
    if (active) begin
      t++;
      if (t == (n_m + 1) * per_m) begin
        e_done = 1;
        frames++;
        for (int i = 0; i < 80; i++) exp_val[i] = (i < n_m) ? chain_vec[i] : 1'b0;
        if (ctrl_valid(ctrl_m)) start_frame(); else active = 0;
      end
    end else if (ctrl_valid(ctrl_m)) start_frame();
    if (pc) begin ctrl_m = pc_val & 32'hFFFF_03C1; pc = 0; end
    if (pl) begin
      for (int i = 0; i < 80; i++) if (i / 32 == pl_b) latch_m[i] = pl_val[i%32];
      pl = 0;
    end
    if (active) begin
      if (t < per_m) e_ld = 1;
      else begin
        e_clk = ((t - per_m) % per_m) >= per_m / 2;
        e_do  = snap_m[n_m - 1 - (t - per_m) / per_m];
      end
    end
    // R4 R3 R8 clock and strobe, R5 data, R7 done pulse
    chk(sclk_o == e_clk, active ? "R4 sclk" : "R8/R3 sclk idle", 32'(sclk_o), 32'(e_clk));
    chk(sload_o == e_ld, active ? "R4 strobe" : "R8/R3 strobe idle", 32'(sload_o), 32'(e_ld));
    chk(sdout_o == e_do, "R5 sdout", 32'(sdout_o), 32'(e_do));
    chk(frame_done_o == e_done, "R7 frame_done", 32'(frame_done_o), 32'(e_done));
    // R6 R11 value path, R10 latch path, R2 control read-back
    chk(rd_value == slice(exp_val, int'(rd_bank)), "R6/R11 rd_value", rd_value, slice(exp_val, int'(rd_bank)));
    chk(rd_latch == slice(latch_m, int'(rd_bank)), "R10 rd_latch", rd_latch, slice(latch_m, int'(rd_bank)));
    chk(ctrl_rdata == ctrl_m, "R2 ctrl_rdata", ctrl_rdata, ctrl_m);
    // external chain model
    if (sload_o) begin chain_vec = in_pins; chain_idx = n_m - 1; end
    else if (sclk_o && !prev_sclk) chain_idx--;
    prev_sclk = sclk_o;
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && mon_on && !finished) mon_step();
  end

  task automatic wr_ctrl(logic [31:0] v);
    @(negedge clk);
    ctrl_we = 1; ctrl_wdata = v; pc_val = v; pc = 1;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic wr_lat(int b, logic [31:0] v);
    @(negedge clk);
    lat_we = 1; lat_bank = 2'(b); lat_wdata = v; pl_b = b; pl_val = v; pl = 1;
    @(negedge clk);
    lat_we = 0;
  endtask

  function automatic logic [31:0] mk_ctrl(bit en, int grp, int div);
    return {16'(div), 6'd0, 4'(grp), 5'd0, en};
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({sclk_o, sload_o, sdout_o, frame_done_o} == 4'b0, "R1 serial pins in reset",
        32'({sclk_o, sload_o, sdout_o, frame_done_o}), 0);
    rst_n = 1;
    @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      rd_bank = 2'(b); #1;
      chk(rd_value == 0 && rd_latch == 0, "R1 banks after reset", rd_value | rd_latch, 0);
    end
    chk(ctrl_rdata == 0, "R1 ctrl after reset", ctrl_rdata, 0);
    rd_bank = 0;
    mon_on = 1;

    // R10 latch writes, pad bits and bank 3 ignored
    wr_lat(0, 32'hA5C3_0F12);
    wr_lat(1, 32'h1357_9BDF);
    wr_lat(2, 32'hBEEF_1234);
    wr_lat(3, 32'hFFFF_FFFF);
    @(negedge clk); rd_bank = 2; #1;
    chk(rd_latch == 32'h0000_1234, "R10 bank 2 upper bits", rd_latch, 32'h0000_1234);
    @(negedge clk); rd_bank = 3; #1;
    chk(rd_latch == 0, "R10 bank 3 ignored", rd_latch, 0);

    // R2 reserved bits dropped; R3 invalid groups never shift
    wr_ctrl(32'h0000_FC3F & ~32'h3C0 | 32'h1);
    repeat (200) @(negedge clk);
    wr_ctrl(mk_ctrl(1, 11, 0));
    repeat (200) @(negedge clk);
    wr_ctrl(mk_ctrl(0, 4, 0));
    repeat (100) @(negedge clk);
    chk(frames == 0, "R3 no frame while invalid", frames, 0);

    // R4..R7 small chain, fastest clock
    rd_bank = 0;
    in_pins = 80'h0_0000_0000_0000_0000_5A;
    wr_ctrl(mk_ctrl(1, 1, 0));
    repeat (40) @(negedge clk);
    in_pins = 80'h0_0000_0000_0000_0000_C3;
    repeat (40) @(negedge clk);
    wr_lat(0, 32'h0000_0081);
    repeat (60) @(negedge clk);

    // R9 full chain, divider change mid-frame
    in_pins = 80'hF0E1_D2C3_B4A5_9687_7869;
    wr_ctrl(mk_ctrl(1, 10, 3));
    repeat (300) @(negedge clk);
    wr_ctrl(mk_ctrl(1, 10, 1));
    rd_bank = 1;
    repeat (700) @(negedge clk);
    in_pins = 80'h0123_4567_89AB_CDEF_0F1E;
    wr_lat(2, 32'h0000_8001);
    rd_bank = 2;
    repeat (800) @(negedge clk);

    // R8 disable mid-frame
    f0 = frames;
    wr_ctrl(mk_ctrl(0, 10, 1));
    repeat (600) @(negedge clk);
    chk(frames == f0 + 1, "R8 frame finished after disable", frames, f0 + 1);
    repeat (50) @(negedge clk);

    // R6 R11 odd divider, three groups
    in_pins = 80'h0_0000_0000_00AB_CD_EF_12;
    rd_bank = 0;
    wr_ctrl(mk_ctrl(1, 3, 2));
    repeat (400) @(negedge clk);
    rd_bank = 3;
    repeat (20) @(negedge clk);
    chk(rd_value == 0, "R11 bank 3 value", rd_value, 0);
    rd_bank = 0;
    wr_ctrl(mk_ctrl(0, 3, 2));
    repeat (300) @(negedge clk);
    chk(frames > 8, "R7 frames completed", frames, 9);
    finish_run();
  end

endmodule